// File: doc/BRIEF.md
# Charge Current Setpoint Sequencer

This block produces the digital reference code that the charge-current regulation loop follows. A programmed current code sets the goal. The block ramps the reference up to that goal in a fixed number of equal soft-start steps every time charging becomes active. It lowers the goal to one eighth while the battery is flagged as deeply discharged, so that the pack gets a gentle pre-charge. It also gates the converter through three protections. A hysteretic overvoltage latch and an instantaneous overcurrent flag both inhibit the high-side switch. A hysteretic thermal latch stops charging altogether.

Protection thresholds are compared outside the block, and their results arrive as single-bit comparator outputs. Each hysteretic pair uses one bit that trips the latch and another bit that releases it. All outputs are registered, so every result appears one clock after the inputs that cause it. One soft-start step lasts `STEP_CYCLES` clocks, which is about 1 ms at the intended clock.

Top module: `chg_iref_seq`

## Requirements
- R1: While `rst` is high, the outputs settle to `iref_code` = 0, `run_en` = 0 and `hs_inhibit` = 1.
- R2: Charging is active when `chg_en` = 1, `learn` = 0 and the thermal latch is clear. At the first clock on which it becomes active, the step count starts at 1. The count then rises by one every `STEP_CYCLES` clocks until it reaches 8. `iref_code` = floor(goal × step / 8), so the full goal is reached 7 × `STEP_CYCLES` clocks after the first step.
- R3: When `chg_en` = 0 or `learn` = 1, `iref_code` is 0 and `run_en` is 0 one clock later. The step count is cleared, so the next activation ramps from step 1 again.
- R4: While `bat_short` = 1, the goal is floor(`prog_code` / 8).
- R5: When `bat_short` returns to 0, the goal is `prog_code` again. After the ramp has completed, `iref_code` equals `prog_code` one clock later.
- R6: If the goal changes during a ramp, the step count is kept. The reference continues as floor(new goal × step / 8).
- R7: `ov_trip` = 1 sets the overvoltage latch and `ov_clear` = 1 clears it, with set taking priority. `hs_inhibit` is 1 one clock after the latch is set, and it stays 1 until one clock after the latch clears.
- R8: `oc_flag` = 1 forces `hs_inhibit` to 1 on the next clock. `hs_inhibit` drops automatically one clock after `oc_flag` falls, provided nothing else holds it.
- R9: `hot_trip` = 1 sets the thermal latch and `hot_clear` = 1 clears it, with set taking priority. While the latch is set, `run_en` = 0 and `iref_code` = 0. After it clears, charging restarts from step 1.
- R10: `hs_inhibit` is also 1 whenever charging is not active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_code | input | CODE_W | Programmed full charge-current code |
| chg_en | input | 1 | Charge enable request |
| learn | input | 1 | Battery learn cycle active; suppresses charging |
| bat_short | input | 1 | Battery below short threshold (pre-charge) |
| ov_trip | input | 1 | Battery above upper overvoltage threshold |
| ov_clear | input | 1 | Battery below lower overvoltage threshold |
| oc_flag | input | 1 | Charge current above overcurrent threshold |
| hot_trip | input | 1 | Junction temperature above shutdown threshold |
| hot_clear | input | 1 | Junction temperature below release threshold |
| iref_code | output | CODE_W | Charge-current reference code |
| run_en | output | 1 | Converter run enable |
| hs_inhibit | output | 1 | High-side switch inhibit |

## Verification
Every result is due exactly one clock after the edge that samples its inputs. The bench drives inputs on falling edges and reads outputs on the next falling edge, after exactly one rising edge has passed. Soft-start steps land 1 + `STEP_CYCLES` × (k − 1) clocks after activation. The directed checks count edges to those instants, including the clock just before a step boundary. A behavioural model, advanced on every rising edge, predicts all three outputs, and each falling edge compares them, so random protection and goal changes are also checked to the cycle.

// File: rtl/chg_iref_pkg.sv
package chg_iref_pkg;
  localparam int STEP_COUNT = 8;
  localparam int STEP_LOG2  = 3;
  localparam int STEP_W     = STEP_LOG2 + 1;
endpackage

// File: rtl/hyst_latch.sv
module hyst_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  assign nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end

  // R7 / R9: set wins and the latch holds until released
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/ss_stepper.sv
module ss_stepper
  import chg_iref_pkg::*;
#(
  parameter int STEP_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  output logic [STEP_W-1:0] step_nxt_o
);
  localparam int TW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [TW-1:0]     T_LAST = TW'(STEP_CYCLES - 1);
  localparam logic [STEP_W-1:0] S_TOP  = STEP_W'(STEP_COUNT);

  logic              act_q;
  logic [STEP_W-1:0] step_q;
  logic [TW-1:0]     tmr_q, tmr_nxt;

  always_comb begin
    step_nxt_o = step_q;
    tmr_nxt    = tmr_q;
    if (!active_i) begin
      step_nxt_o = '0;
      tmr_nxt    = '0;
    end else if (!act_q) begin
      step_nxt_o = STEP_W'(1);
      tmr_nxt    = '0;
    end else if (step_q < S_TOP) begin
      if (tmr_q == T_LAST) begin
        tmr_nxt    = '0;
        step_nxt_o = step_q + STEP_W'(1);
      end else begin
        tmr_nxt = tmr_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      step_q <= '0;
      tmr_q  <= '0;
    end else begin
      act_q  <= active_i;
      step_q <= step_nxt_o;
      tmr_q  <= tmr_nxt;
    end
  end

  // R2: step never passes the top and climbs by at most one per clock
  p_step_cap_r2: assert property (@(posedge clk) disable iff (rst)
    step_q <= S_TOP);
  p_step_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (active_i && step_q != '0) |=>
      (step_q == $past(step_q) || step_q == $past(step_q) + STEP_W'(1)));
  // R3: inactivity clears the step count
  p_step_clr_r3: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> step_q == '0);
endmodule

// File: rtl/ref_scaler.sv
module ref_scaler
  import chg_iref_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] goal_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [CODE_W-1:0] ref_o
);
  localparam int PW = CODE_W + STEP_LOG2;

  logic [PW-1:0] prod;
  logic          unused_lsb;

  assign prod       = {{STEP_LOG2{1'b0}}, goal_i} * PW'(step_i);
  assign ref_o      = prod[PW-1:STEP_LOG2];
  assign unused_lsb = ^prod[STEP_LOG2-1:0];
endmodule

// File: rtl/chg_iref_seq.sv
module chg_iref_seq
  import chg_iref_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int STEP_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] prog_code,
  input  logic              chg_en,
  input  logic              learn,
  input  logic              bat_short,
  input  logic              ov_trip,
  input  logic              ov_clear,
  input  logic              oc_flag,
  input  logic              hot_trip,
  input  logic              hot_clear,
  output logic [CODE_W-1:0] iref_code,
  output logic              run_en,
  output logic              hs_inhibit
);
  logic              ov_nxt, ov_q, hot_nxt, hot_q;
  logic              active;
  logic [CODE_W-1:0] goal, ref_nxt;
  logic [STEP_W-1:0] step_nxt;

  hyst_latch u_ov (
    .clk(clk), .rst(rst), .set_i(ov_trip), .clr_i(ov_clear),
    .nxt_o(ov_nxt), .q_o(ov_q)
  );

  hyst_latch u_hot (
    .clk(clk), .rst(rst), .set_i(hot_trip), .clr_i(hot_clear),
    .nxt_o(hot_nxt), .q_o(hot_q)
  );

  assign active = chg_en & ~learn & ~hot_nxt;
  assign goal   = bat_short ? (prog_code >> STEP_LOG2) : prog_code;

  ss_stepper #(.STEP_CYCLES(STEP_CYCLES)) u_step (
    .clk(clk), .rst(rst), .active_i(active), .step_nxt_o(step_nxt)
  );

  ref_scaler #(.CODE_W(CODE_W)) u_scale (
    .goal_i(goal), .step_i(step_nxt), .ref_o(ref_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iref_code  <= '0;
      run_en     <= 1'b0;
      hs_inhibit <= 1'b1;
    end else begin
      iref_code  <= active ? ref_nxt : '0;
      run_en     <= active;
      hs_inhibit <= ov_nxt | oc_flag | ~active;
    end
  end

  // R3: disable or learn zeroes the reference one clock later
  p_off_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!chg_en || learn) |=> (iref_code == '0 && !run_en));
  // R8: overcurrent inhibits the high side on the next clock
  p_oc_inh_r8: assert property (@(posedge clk) disable iff (rst)
    oc_flag |=> hs_inhibit);
  // R9: thermal trip stops the converter
  p_hot_stop_r9: assert property (@(posedge clk) disable iff (rst)
    hot_trip |=> (!run_en && iref_code == '0));
  // R7: a held overvoltage latch keeps the high side inhibited
  p_ov_inh_r7: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !ov_clear) |=> hs_inhibit);
  // R10: not running implies inhibited
  p_idle_inh_r10: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> hs_inhibit);
  // R2: reference never exceeds the goal
  p_ref_cap_r2: assert property (@(posedge clk) disable iff (rst)
    iref_code <= $past(goal));
  // R9: thermal latch state agrees with the run enable
  p_hot_run_r9: assert property (@(posedge clk) disable iff (rst)
    hot_q |-> !run_en);
endmodule

// File: tb/chg_iref_seq_bench.sv
`timescale 1ns/1ps
module chg_iref_seq_bench;
  localparam int CW = 10;
  localparam int SC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] prog_code = '0;
  logic chg_en = 0, learn = 0, bat_short = 0, ov_trip = 0, ov_clear = 0;
  logic oc_flag = 0, hot_trip = 0, hot_clear = 0;
  logic [CW-1:0] iref_code;
  logic run_en, hs_inhibit;

  int vectors = 0;
  int errors  = 0;
  bit started = 0;
  bit done    = 0;

  // model state
  int m_step = 0, m_tmr = 0, m_iref = 0;
  bit m_ov = 0, m_hot = 0, m_act = 0, m_run = 0, m_hs = 1;

  always #4 clk = ~clk;

  chg_iref_seq #(.CODE_W(CW), .STEP_CYCLES(SC)) u_chg_iref_seq (
    .clk(clk), .rst(rst), .prog_code(prog_code), .chg_en(chg_en),
    .learn(learn), .bat_short(bat_short), .ov_trip(ov_trip),
    .ov_clear(ov_clear), .oc_flag(oc_flag), .hot_trip(hot_trip),
    .hot_clear(hot_clear), .iref_code(iref_code), .run_en(run_en),
    .hs_inhibit(hs_inhibit)
  );

  always @(posedge clk) begin
    int goal;
    bit a;
    started = 1;
    if (rst) begin
      m_step = 0; m_tmr = 0; m_ov = 0; m_hot = 0; m_act = 0;
      m_iref = 0; m_run = 0; m_hs = 1;
    end else begin
      if (hot_trip) m_hot = 1; else if (hot_clear) m_hot = 0;
      if (ov_trip)  m_ov  = 1; else if (ov_clear)  m_ov  = 0;
      a = chg_en && !learn && !m_hot;
      goal = bat_short ? (int'(prog_code) / 8) : int'(prog_code);
      if (!a) begin m_step = 0; m_tmr = 0; end
      else if (!m_act) begin m_step = 1; m_tmr = 0; end
      else if (m_step < 8) begin
        if (m_tmr == SC - 1) begin m_tmr = 0; m_step++; end
        else m_tmr++;
      end
      m_act  = a;
      m_iref = a ? (goal * m_step) / 8 : 0;
      m_run  = a;
      m_hs   = m_ov || oc_flag || !a;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (int'(iref_code) != m_iref) begin
        errors++;
        $display("FAIL R2 model iref_code: got %0d expected %0d at %0t", iref_code, m_iref, $time);
      end
      if (run_en != m_run) begin
        errors++;
        $display("FAIL R3 model run_en: got %0b expected %0b at %0t", run_en, m_run, $time);
      end
      if (hs_inhibit != m_hs) begin
        errors++;
        $display("FAIL R7 model hs_inhibit: got %0b expected %0b at %0t", hs_inhibit, m_hs, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R1 iref", iref_code, 0);
    chk("R1 run", run_en, 0);
    chk("R1 hs", hs_inhibit, 1);
    rst = 0; prog_code = 800; chg_en = 1;
    tick(1);  chk("R2 step1", iref_code, 100); chk("R10 hs low", hs_inhibit, 0);
    tick(3);  chk("R2 step1 held", iref_code, 100);
    tick(1);  chk("R2 step2", iref_code, 200);
    tick(23); chk("R2 step7", iref_code, 700);
    tick(1);  chk("R2 full", iref_code, 800);
    bat_short = 1; tick(1); chk("R4 precharge", iref_code, 100);
    bat_short = 0; tick(1); chk("R5 full again", iref_code, 800);
    ov_trip = 1; tick(1); chk("R7 set", hs_inhibit, 1);
    ov_trip = 0; tick(3); chk("R7 held", hs_inhibit, 1);
    chk("R7 ref kept", iref_code, 800);
    ov_clear = 1; tick(1); chk("R7 release", hs_inhibit, 0);
    ov_clear = 0;
    oc_flag = 1; tick(1); chk("R8 inhibit", hs_inhibit, 1);
    oc_flag = 0; tick(1); chk("R8 resume", hs_inhibit, 0);
    learn = 1; tick(1);
    chk("R3 learn iref", iref_code, 0); chk("R3 learn run", run_en, 0);
    chk("R10 idle hs", hs_inhibit, 1);
    learn = 0; tick(1); chk("R3 restart", iref_code, 100);
    tick(8); chk("R2 step3", iref_code, 300);
    bat_short = 1; tick(1); chk("R6 retarget", iref_code, 37);
    tick(3); chk("R6 step4", iref_code, 50);
    bat_short = 0;
    hot_trip = 1; tick(1);
    chk("R9 stop run", run_en, 0); chk("R9 stop iref", iref_code, 0);
    hot_trip = 0; tick(4); chk("R9 stays off", run_en, 0);
    hot_clear = 1; tick(1);
    chk("R9 resume run", run_en, 1); chk("R9 resume step1", iref_code, 100);
    hot_clear = 0;
    chg_en = 0; tick(1); chk("R3 disable", iref_code, 0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      chg_en    = (r < 90);
      learn     = ($urandom_range(0, 99) < 3);
      bat_short = ($urandom_range(0, 99) < 10);
      ov_trip   = ($urandom_range(0, 99) < 3);
      ov_clear  = ($urandom_range(0, 99) < 10);
      oc_flag   = ($urandom_range(0, 99) < 5);
      hot_trip  = ($urandom_range(0, 99) < 2);
      hot_clear = ($urandom_range(0, 99) < 8);
      if ($urandom_range(0, 99) < 5) prog_code = CW'($urandom_range(0, 1023));
      tick(1);
    end
    finish_run();
  end
endmodule